// File: doc/BRIEF.md
# Super I/O Configuration Unlock Controller

This block is the host-side configuration front end of a legacy multi-function I/O device. It watches an 8-bit I/O write bus. Its configuration space stays locked until software performs a two-stage unlock. The first stage is a four-byte prefix written to a fixed, write-only configuration port, and its last byte picks one of two base addresses. The second stage is a 32-byte key written to that chosen base.

Once the block is unlocked, the base address becomes an index port and the next address becomes a data port. An index register selects which register a data write reaches. A logical-device-number register selects the bank of per-device registers. The outputs of the block are:

- a global device-enable mask,
- one activate bit for each logical device,
- a clock-input select bit,
- a software-suspend bit.

Software leaves configuration mode by writing the configure-control register. Register contents survive exit and re-entry until reset.

Top module: `sio_cfg_unlock`

## Requirements
- R1: A synchronous active-low reset gives the following state: the matcher is idle and `cfg_mode` = 0; the logical device number is 0; `dev_enable` = 0x00; all `dev_active` bits are 0; `clk_sel_48` = 0 (24 MHz); and `soft_suspend` = 0.
- R2: Writing 0x86, 0x80, 0x55, 0x55 in order to address 0x0279, then the 32-byte key to address 0x03f0, sets `cfg_mode` to 1 one clock after the last key write.
- R3: A final prefix byte of 0xaa selects base 0x03bd instead. In that case key writes to 0x03f0 are ignored, and key writes to 0x03bd unlock the block.
- R4: The key starts at 0x6a. Each following byte is the previous byte shifted right by one, with (bit0 XOR bit1) of the previous byte placed in bit 7. All 32 bytes are needed: after 31 of them `cfg_mode` is still 0.
- R5: A prefix or key byte that does not match sends the matcher back to idle, so the prefix must be written again. If the mismatching byte equals the first byte of its stage (0x86 for the prefix, 0x6a for the key), matching instead restarts at step one of that stage.
- R6: In configuration mode, the base address is the index port and base+1 is the data port. While `cfg_mode` = 0, writes to either port change no output.
- R7: Data written to index 0x07 sets the logical device number. A data write to index 0x30 loads bit 0 of the data into `dev_active[LDN]`. The global registers (indexes 0x02, 0x23 and 0x24) react only when the logical device number is 0.
- R8: A data write to global index 0x23 loads `dev_enable`. The bit map is: bit0 floppy, bit1 serial 1, bit2 serial 2, bit3 parallel, bit5 keyboard, bit6 mouse. Bits 4 and 7 are reserved and always read as 0.
- R9: A data write to global index 0x24 loads `clk_sel_48` from data bit 6 (1 = 48 MHz) and `soft_suspend` from data bit 0.
- R10: A data write to global index 0x02 with data bit 1 set leaves configuration mode; with bit 1 clear the block stays in configuration mode. Register contents persist across exit and re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| cfg_mode | output | 1 | Configuration mode active |
| dev_enable | output | 8 | Global device-enable mask |
| dev_active | output | 8 | Activate bit per logical device |
| clk_sel_48 | output | 1 | 1 = 48 MHz clock input, 0 = 24 MHz |
| soft_suspend | output | 1 | Software suspend |

## Verification
Every output is a register that is loaded on the clock edge that accepts the write. A write presented in a cycle therefore shows up on `cfg_mode`, `dev_enable`, `dev_active`, `clk_sel_48` or `soft_suspend` exactly one edge later. Exit works the same way, with `cfg_mode` dropping one edge after the control write. The bench drives each write for a single cycle starting at a falling edge and compares the outputs at the next falling edge. This places each comparison half a period after the edge where the result is due.

// File: rtl/sio_cfg_pkg.sv
// Shared types and helpers for the configuration unlock controller.
// Assumes an 8-bit key byte stream that advances by a fixed shift rule.
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREFIX = 2'd1,
        ST_KEY    = 2'd2,
        ST_OPEN   = 2'd3
    } unlock_st_e;

    // Next key byte: shift right, feedback bit0^bit1 into bit 7.
    function automatic logic [7:0] key_next(input logic [7:0] v);
        return {v[0] ^ v[1], v[7:1]};
    endfunction

endpackage

// File: rtl/sio_unlock_seq.sv
// Two-stage unlock matcher. Stage one compares writes at the configuration
// port against a four-byte prefix whose last byte picks the base address.
// Stage two compares writes at that base against a generated key stream.
// Assumes one write per strobe cycle; writes to other addresses are ignored.
module sio_unlock_seq
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0] BASE_A   = 16'h03f0,
    parameter logic [ADDR_W-1:0] BASE_B   = 16'h03bd,
    parameter logic [7:0]        PFX0     = 8'h86,
    parameter logic [7:0]        PFX1     = 8'h80,
    parameter logic [7:0]        PFX2     = 8'h55,
    parameter logic [7:0]        SEL_A    = 8'h55,
    parameter logic [7:0]        SEL_B    = 8'haa,
    parameter logic [7:0]        KEY_SEED = 8'h6a,
    parameter int                KEY_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              exit_req,
    output logic              cfg_open,
    output logic [ADDR_W-1:0] base_addr
);

    localparam int                CNT_W    = $clog2(KEY_LEN);
    localparam logic [CNT_W-1:0]  STEP_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0]  STEP_TWO = CNT_W'(2);
    localparam logic [CNT_W-1:0]  STEP_SEL = CNT_W'(3);
    localparam logic [CNT_W-1:0]  STEP_END = CNT_W'(KEY_LEN - 1);

    unlock_st_e       st_q, st_d;
    logic [CNT_W-1:0] step_q, step_d;
    logic [7:0]       key_q, key_d;
    logic             sel_q, sel_d;
    logic             hit_cfg, hit_base;

    assign base_addr = sel_q ? BASE_B : BASE_A;
    assign hit_cfg   = wr_en && (wr_addr == CFG_PORT);
    assign hit_base  = wr_en && (wr_addr == base_addr);
    assign cfg_open  = (st_q == ST_OPEN);

    // Next-state logic of the prefix/key matcher.
    always_comb begin
        st_d   = st_q;
        step_d = step_q;
        key_d  = key_q;
        sel_d  = sel_q;
        case (st_q)
            ST_IDLE: begin
                if (hit_cfg && wr_data == PFX0) begin
                    st_d   = ST_PREFIX;
                    step_d = STEP_ONE;
                end
            end
            ST_PREFIX: begin
                if (hit_cfg) begin
                    if (step_q == STEP_ONE && wr_data == PFX1) begin
                        step_d = STEP_TWO;
                    end else if (step_q == STEP_TWO && wr_data == PFX2) begin
                        step_d = STEP_SEL;
                    end else if (step_q == STEP_SEL &&
                                 (wr_data == SEL_A || wr_data == SEL_B)) begin
                        st_d   = ST_KEY;
                        step_d = '0;
                        sel_d  = (wr_data == SEL_B);
                        key_d  = KEY_SEED;
                    end else if (wr_data == PFX0) begin
                        step_d = STEP_ONE;
                    end else begin
                        st_d   = ST_IDLE;
                        step_d = '0;
                    end
                end
            end
            ST_KEY: begin
                if (hit_base) begin
                    if (wr_data == key_q) begin
                        key_d = key_next(key_q);
                        if (step_q == STEP_END) begin
                            st_d   = ST_OPEN;
                            step_d = '0;
                        end else begin
                            step_d = step_q + 1'b1;
                        end
                    end else if (wr_data == KEY_SEED) begin
                        step_d = STEP_ONE;
                        key_d  = key_next(KEY_SEED);
                    end else begin
                        st_d   = ST_IDLE;
                        step_d = '0;
                    end
                end
            end
            ST_OPEN: begin
                if (exit_req) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Matcher state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            key_q  <= KEY_SEED;
            sel_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            key_q  <= key_d;
            sel_q  <= sel_d;
        end
    end

endmodule

// File: rtl/sio_cfg_regs.sv
// Index/data register file opened by the unlock matcher. The base address
// is the index port and base+1 is the data port. The logical device number
// banks the per-device registers; the global registers answer only on device 0.
// Assumes the matcher drops cfg_open on the cycle after exit_req.
module sio_cfg_regs #(
    parameter int         ADDR_W     = 16,
    parameter int         NUM_LDN    = 8,
    parameter logic [7:0] IDX_LDN    = 8'h07,
    parameter logic [7:0] IDX_CTRL   = 8'h02,
    parameter logic [7:0] IDX_DEVEN  = 8'h23,
    parameter logic [7:0] IDX_CLK    = 8'h24,
    parameter logic [7:0] IDX_ACT    = 8'h30,
    parameter logic [7:0] DEVEN_MASK = 8'h6f,
    parameter int         EXIT_BIT   = 1,
    parameter int         CLK_BIT    = 6,
    parameter int         SUSP_BIT   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_open,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic               exit_req,
    output logic [7:0]         dev_enable,
    output logic [NUM_LDN-1:0] dev_active,
    output logic               clk_sel_48,
    output logic               soft_suspend
);

    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic       idx_wr, dat_wr, glb_wr;

    assign idx_wr   = cfg_open && wr_en && (wr_addr == base_addr);
    assign dat_wr   = cfg_open && wr_en && (wr_addr == (base_addr + 1'b1));
    assign glb_wr   = dat_wr && (ldn_q == 8'h00);
    assign exit_req = glb_wr && (index_q == IDX_CTRL) && wr_data[EXIT_BIT];

    // Index pointer and logical device number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else begin
            if (idx_wr) begin
                index_q <= wr_data;
            end
            if (dat_wr && index_q == IDX_LDN) begin
                ldn_q <= wr_data;
            end
        end
    end

    // Global enable mask and clock/suspend register, device 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_enable   <= 8'h00;
            clk_sel_48   <= 1'b0;
            soft_suspend <= 1'b0;
        end else if (glb_wr) begin
            if (index_q == IDX_DEVEN) begin
                dev_enable <= wr_data & DEVEN_MASK;
            end
            if (index_q == IDX_CLK) begin
                clk_sel_48   <= wr_data[CLK_BIT];
                soft_suspend <= wr_data[SUSP_BIT];
            end
        end
    end

    // One activate bit per logical device, selected by the bank number.
    for (genvar g = 0; g < NUM_LDN; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dev_active[g] <= 1'b0;
            end else if (dat_wr && index_q == IDX_ACT && ldn_q == 8'(g)) begin
                dev_active[g] <= wr_data[0];
            end
        end
    end

endmodule

// File: rtl/sio_cfg_unlock.sv
// Top of the configuration unlock controller: connects the two-stage unlock
// matcher to the banked register file. Assumes a single-cycle write strobe.
module sio_cfg_unlock #(
    parameter int ADDR_W  = 16,
    parameter int NUM_LDN = 8,
    parameter int KEY_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [7:0]         io_wdata,
    output logic               cfg_mode,
    output logic [7:0]         dev_enable,
    output logic [NUM_LDN-1:0] dev_active,
    output logic               clk_sel_48,
    output logic               soft_suspend
);

    logic              exit_req;
    logic [ADDR_W-1:0] base_addr;

    sio_unlock_seq #(
        .ADDR_W (ADDR_W),
        .KEY_LEN(KEY_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_wr),
        .wr_addr  (io_addr),
        .wr_data  (io_wdata),
        .exit_req (exit_req),
        .cfg_open (cfg_mode),
        .base_addr(base_addr)
    );

    sio_cfg_regs #(
        .ADDR_W (ADDR_W),
        .NUM_LDN(NUM_LDN)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_open    (cfg_mode),
        .base_addr   (base_addr),
        .wr_en       (io_wr),
        .wr_addr     (io_addr),
        .wr_data     (io_wdata),
        .exit_req    (exit_req),
        .dev_enable  (dev_enable),
        .dev_active  (dev_active),
        .clk_sel_48  (clk_sel_48),
        .soft_suspend(soft_suspend)
    );

endmodule

// File: rtl/sio_cfg_unlock_chk.sv
// Port-level checker for the unlock controller, bound to every instance.
// Assumes synchronous active-low reset; all properties are off during reset.
module sio_cfg_unlock_chk #(
    parameter int ADDR_W  = 16,
    parameter int NUM_LDN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_wr,
    input logic [ADDR_W-1:0]  io_addr,
    input logic [7:0]         io_wdata,
    input logic               cfg_mode,
    input logic [7:0]         dev_enable,
    input logic [NUM_LDN-1:0] dev_active,
    input logic               clk_sel_48,
    input logic               soft_suspend
);

    AST_ENTRY_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_mode) && $past(rst_n)) |->
            ($past(io_wr) && ($past(io_addr) == 16'h03f0 || $past(io_addr) == 16'h03bd))); // R2

    AST_EXIT_BY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_mode) && $past(rst_n)) |-> ($past(io_wr) && $past(io_wdata[1]))); // R10

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode) |=> ($stable(dev_enable) && $stable(dev_active) &&
                         $stable(clk_sel_48) && $stable(soft_suspend))); // R6

    AST_ONE_ACT_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(dev_active ^ $past(dev_active)) <= 1)); // R7

    AST_CLK_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(clk_sel_48) && $past(rst_n)) |-> $past(cfg_mode && io_wr)); // R9

endmodule

bind sio_cfg_unlock sio_cfg_unlock_chk #(
    .ADDR_W (ADDR_W),
    .NUM_LDN(NUM_LDN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .cfg_mode    (cfg_mode),
    .dev_enable  (dev_enable),
    .dev_active  (dev_active),
    .clk_sel_48  (clk_sel_48),
    .soft_suspend(soft_suspend)
);

// File: tb/sio_cfg_unlock_bench.sv
// Self-checking bench: unlock, a vector table of register writes, then
// directed tests for exit, persistence, base select, mismatches and reset.
module sio_cfg_unlock_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic        cfg_mode;
    logic [7:0]  dev_enable;
    logic [7:0]  dev_active;
    logic        clk_sel_48;
    logic        soft_suspend;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sio_cfg_unlock u_sio_cfg_unlock (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .cfg_mode(cfg_mode), .dev_enable(dev_enable),
        .dev_active(dev_active), .clk_sel_48(clk_sel_48),
        .soft_suspend(soft_suspend)
    );

    // Vector: addr, data, exp mode, exp enable, exp active, exp clk48, exp susp
    localparam int NV = 20;
    localparam logic [42:0] VEC [NV] = '{
        {16'h03f0, 8'h23, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0},
        {16'h03f1, 8'hff, 1'b1, 8'h6f, 8'h00, 1'b0, 1'b0}, // R8 reserved masked
        {16'h03f0, 8'h24, 1'b1, 8'h6f, 8'h00, 1'b0, 1'b0},
        {16'h03f1, 8'h41, 1'b1, 8'h6f, 8'h00, 1'b1, 1'b1}, // R9
        {16'h03f0, 8'h07, 1'b1, 8'h6f, 8'h00, 1'b1, 1'b1},
        {16'h03f1, 8'h03, 1'b1, 8'h6f, 8'h00, 1'b1, 1'b1},
        {16'h03f0, 8'h30, 1'b1, 8'h6f, 8'h00, 1'b1, 1'b1},
        {16'h03f1, 8'h01, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1}, // R7 ldn 3
        {16'h03f0, 8'h23, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1},
        {16'h03f1, 8'h00, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1}, // R7 global blocked
        {16'h03f0, 8'h07, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1},
        {16'h03f1, 8'h01, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1},
        {16'h03f0, 8'h30, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1},
        {16'h03f1, 8'hfe, 1'b1, 8'h6f, 8'h08, 1'b1, 1'b1}, // R7 bit0 only
        {16'h03f1, 8'h01, 1'b1, 8'h6f, 8'h0a, 1'b1, 1'b1},
        {16'h03f0, 8'h07, 1'b1, 8'h6f, 8'h0a, 1'b1, 1'b1},
        {16'h03f1, 8'h00, 1'b1, 8'h6f, 8'h0a, 1'b1, 1'b1},
        {16'h03f0, 8'h24, 1'b1, 8'h6f, 8'h0a, 1'b1, 1'b1},
        {16'h03f1, 8'h40, 1'b1, 8'h6f, 8'h0a, 1'b1, 1'b0}, // R9
        {16'h03f0, 8'h02, 1'b1, 8'h6f, 8'h0a, 1'b1, 1'b0}
    };

    function automatic logic [7:0] key_byte(input int n);
        logic [7:0] v = 8'h6a;
        for (int i = 0; i < n; i++) v = {v[0] ^ v[1], v[7:1]};
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic prefix(input logic [7:0] last);
        wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
        wr(16'h0279, 8'h55); wr(16'h0279, last);
    endtask

    task automatic key(input logic [15:0] base, input int from, input int upto);
        for (int i = from; i < upto; i++) wr(base, key_byte(i));
    endtask

    task automatic leave(input logic [15:0] base);
        wr(base, 8'h07); wr(base + 16'h1, 8'h00);
        wr(base, 8'h02); wr(base + 16'h1, 8'h02);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 mode", {31'd0, cfg_mode}, 0);
        chk("R1 enable", {24'd0, dev_enable}, 0);
        chk("R1 active", {24'd0, dev_active}, 0);
        chk("R1 clk/susp", {30'd0, clk_sel_48, soft_suspend}, 0);

        // R2 / R4: 31 key bytes do not unlock, 32nd does
        prefix(8'h55);
        key(16'h03f0, 0, 31);
        chk("R4 31 bytes", {31'd0, cfg_mode}, 0);
        key(16'h03f0, 31, 32);
        chk("R2 unlock 3f0", {31'd0, cfg_mode}, 1);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][42:27], VEC[v][26:19]);
            chk("R6 R7 R8 R9 vec mode", {31'd0, cfg_mode}, {31'd0, VEC[v][18]});
            chk("R8 vec enable", {24'd0, dev_enable}, {24'd0, VEC[v][17:10]});
            chk("R7 vec active", {24'd0, dev_active}, {24'd0, VEC[v][9:2]});
            chk("R9 vec clk/susp", {30'd0, clk_sel_48, soft_suspend}, {30'd0, VEC[v][1:0]});
        end

        // R10: bit1 clear keeps mode, bit1 set exits
        wr(16'h03f1, 8'h01);
        chk("R10 no exit", {31'd0, cfg_mode}, 1);
        wr(16'h03f1, 8'h02);
        chk("R10 exit", {31'd0, cfg_mode}, 0);

        // R6: writes while locked change nothing
        wr(16'h03f0, 8'h23); wr(16'h03f1, 8'h00);
        wr(16'h03f0, 8'h24); wr(16'h03f1, 8'h00);
        chk("R6 locked enable", {24'd0, dev_enable}, 32'h6f);
        chk("R6 locked clk", {31'd0, clk_sel_48}, 1);

        // R10 persistence on re-entry
        prefix(8'h55); key(16'h03f0, 0, 32);
        chk("R10 reenter", {31'd0, cfg_mode}, 1);
        chk("R10 keep enable", {24'd0, dev_enable}, 32'h6f);
        chk("R10 keep active", {24'd0, dev_active}, 32'h0a);
        leave(16'h03f0);

        // R3: alternate base
        prefix(8'haa);
        key(16'h03f0, 0, 32);
        chk("R3 wrong base", {31'd0, cfg_mode}, 0);
        key(16'h03bd, 0, 32);
        chk("R3 unlock 3bd", {31'd0, cfg_mode}, 1);
        wr(16'h03bd, 8'h24); wr(16'h03be, 8'h00);
        chk("R3 data port 3be", {31'd0, clk_sel_48}, 0);
        leave(16'h03bd);
        chk("R3 exit", {31'd0, cfg_mode}, 0);

        // R5: prefix restart on 0x86
        wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
        prefix(8'h55); key(16'h03f0, 0, 32);
        chk("R5 prefix restart", {31'd0, cfg_mode}, 1);
        leave(16'h03f0);

        // R5: prefix mismatch goes idle
        wr(16'h0279, 8'h86); wr(16'h0279, 8'h80); wr(16'h0279, 8'h11);
        wr(16'h0279, 8'h55); wr(16'h0279, 8'h55);
        key(16'h03f0, 0, 32);
        chk("R5 prefix mismatch", {31'd0, cfg_mode}, 0);

        // R5: key restart on 0x6a
        prefix(8'h55); key(16'h03f0, 0, 5);
        wr(16'h03f0, 8'h6a);
        key(16'h03f0, 1, 32);
        chk("R5 key restart", {31'd0, cfg_mode}, 1);
        leave(16'h03f0);

        // R5: key mismatch goes idle
        prefix(8'h55); key(16'h03f0, 0, 3);
        wr(16'h03f0, 8'h00);
        key(16'h03f0, 0, 32);
        chk("R5 key mismatch", {31'd0, cfg_mode}, 0);

        // R1: reset while in configuration mode
        prefix(8'h55); key(16'h03f0, 0, 32);
        do_reset();
        chk("R1 mid reset mode", {31'd0, cfg_mode}, 0);
        chk("R1 mid reset outs", {15'd0, dev_enable, dev_active, clk_sel_48}, 0);

        // R1 / R7: logical device number cleared by reset
        prefix(8'h55); key(16'h03f0, 0, 32);
        wr(16'h03f0, 8'h30); wr(16'h03f1, 8'h01);
        chk("R7 ldn zero after reset", {24'd0, dev_active}, 32'h01);

        done = 1'b1;
        finish_run();
    end

endmodule